// File: doc/BRIEF.md
# Speaker Output Stage Protection Controller

This controller governs power sequencing and fault handling for two audio output power stages: a headphone driver and a differential class-D speaker driver. Software sets a power bit per stage through a small paged register port. Each stage then passes through a counter-based soft-start ramp before it reports itself as fully up. The analog drivers and the current and temperature sensors lie outside the block. They appear only as two asynchronous fault inputs, and each input passes through a two-flop synchronizer before any logic uses it.

An overcurrent event on the speaker stage sets a latch. The latch keeps the stage off until one of two things happens. A dedicated stage reset, which is a write of 1 to the speaker power bit while the latch is set, clears only the latch. A master reset, from the reset pin or from a software-reset register bit, clears the latch and returns every register to its default. An overtemperature condition works differently. It stops speaker switching only while the die is hot, and switching comes back without any action from software. A saturating counter records the stage resets issued since the last master reset and raises a warning once more than three have occurred.

Top module: `spk_guard`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, every enable, ramp, ready and switching output is 0 and the status byte (page 0, address 3) reads 0x00.
- R2: Writing page 1 address 31 sets the headphone power bit from data bit 7 (1 = up, 0 = down). The headphone stage follows this bit independently of the speaker stage, and the bit reads back at bit 7 of the same address.
- R3: After a stage's request rises, the stage asserts its enable with its ramp flag for exactly RAMP_LEN cycles and then shows ready. Status bit 3 (headphone) and status bit 4 (speaker) show the ready states.
- R4: Dropping a stage's request during its ramp turns the stage fully off on the next clock edge.
- R5: A high level on `oc_in` reaches the logic two edges later and then sets the overcurrent latch. The latch turns the speaker stage off, stays set after `oc_in` returns low, and reads at status bit 0.
- R6: A write of page 1 address 32 with data bit 7 = 1 while the latch is set clears the latch and counts one stage reset. The headphone stage and all power bits are left as they were.
- R7: If the synchronized overcurrent is still high in the cycle of a stage reset, the latch stays set and the speaker stage stays off.
- R8: Overcurrent wins over a speaker power-up write that lands in the same cycle as the latch setting: the speaker stage never leaves off.
- R9: While the synchronized `ot_in` is high, `spk_sw_en` is 0 and status bit 1 is 1. Switching resumes once it falls. Writes to the status address have no effect.
- R10: A write of page 0 address 1 with data bit 0 = 1 acts as a master reset, the same as `rst`: power bits, latch, reset counter and both stages return to default.
- R11: The stage-reset counter saturates at 2^CNT_W-1. Status bit 2 is set while the count exceeds WARN_AT (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| wr_en | input | 1 | Register write strobe |
| page | input | 8 | Register page select |
| addr | input | 7 | Register address within page |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for page/addr (combinational) |
| oc_in | input | 1 | Asynchronous speaker overcurrent indication |
| ot_in | input | 1 | Asynchronous overtemperature indication |
| hp_en | output | 1 | Headphone stage enabled (ramping or up) |
| hp_ramp | output | 1 | Headphone soft-start in progress |
| hp_ready | output | 1 | Headphone stage fully up |
| spk_en | output | 1 | Speaker stage enabled (ramping or up) |
| spk_ramp | output | 1 | Speaker soft-start in progress |
| spk_ready | output | 1 | Speaker stage fully up |
| spk_sw_en | output | 1 | Speaker output switching allowed |

## Verification
The bench builds the block with RAMP_LEN = 16 in place of 256. This shortens every soft-start, so one run can fit many power-ups, aborted ramps and latch-and-recover cycles. CNT_W stays at 3, which keeps saturation of the reset counter at 7 within a short loop of overcurrent events. The bench also places the same-cycle race between the overcurrent latch setting and a power-up write on an exact edge.

// File: rtl/spk_guard_pkg.sv
package spk_guard_pkg;

    localparam int PAGE_W = 8;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RAMP = 2'd1,
        ST_ON   = 2'd2
    } stage_e;

    typedef struct packed {
        logic en;
        logic ramp;
        logic ready;
    } stage_stat_t;

    localparam logic [PAGE_W-1:0] PG_CORE  = 8'd0;
    localparam logic [PAGE_W-1:0] PG_DRV   = 8'd1;
    localparam logic [ADDR_W-1:0] RA_SWRST = 7'd1;
    localparam logic [ADDR_W-1:0] RA_STAT  = 7'd3;
    localparam logic [ADDR_W-1:0] RA_HP    = 7'd31;
    localparam logic [ADDR_W-1:0] RA_SPK   = 7'd32;

    localparam int B_PWR    = 7;
    localparam int B_SWRST  = 0;
    localparam int B_OC     = 0;
    localparam int B_OT     = 1;
    localparam int B_WARN   = 2;
    localparam int B_HPRDY  = 3;
    localparam int B_SPKRDY = 4;

    localparam int N_STAGE = 2;
    localparam int IDX_HP  = 0;
    localparam int IDX_SPK = 1;

    function automatic logic reg_hit(
        input logic [PAGE_W-1:0] pg,
        input logic [ADDR_W-1:0] ra,
        input logic [PAGE_W-1:0] want_pg,
        input logic [ADDR_W-1:0] want_ra
    );
        return (pg == want_pg) && (ra == want_ra);
    endfunction

endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/sg_ramp.sv
module sg_ramp
    import spk_guard_pkg::*;
#(
    parameter int RAMP_LEN = 256
) (
    input  logic        clk,
    input  logic        clr,
    input  logic        req,
    output stage_stat_t stat
);
    localparam int CW = (RAMP_LEN > 2) ? $clog2(RAMP_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(RAMP_LEN - 1);

    stage_e        st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr || !req) begin
            st  <= ST_OFF;
            cnt <= '0;
        end else begin
            case (st)
                ST_OFF: begin
                    st  <= ST_RAMP;
                    cnt <= '0;
                end
                ST_RAMP: begin
                    if (cnt == LAST) st <= ST_ON;
                    else             cnt <= cnt + 1'b1;
                end
                default: st <= st;
            endcase
        end
    end

    always_comb begin
        stat.en    = (st != ST_OFF);
        stat.ramp  = (st == ST_RAMP);
        stat.ready = (st == ST_ON);
    end
endmodule

// File: rtl/sg_ctrl.sv
module sg_ctrl
    import spk_guard_pkg::*;
#(
    parameter int CNT_W   = 3,
    parameter int WARN_AT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] page,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              oc_s,
    input  logic              ot_s,
    input  logic              hp_ready,
    input  logic              spk_ready,
    output logic              master,
    output logic              hp_pwr,
    output logic              spk_pwr,
    output logic              oc_latched,
    output logic              stage_clr,
    output logic              warn,
    output logic [DATA_W-1:0] rdata
);
    logic             sw_rst, wr_hp, wr_spk;
    logic [CNT_W-1:0] rst_cnt;
    wire              unused_wbits = ^wdata[6:1];

    assign sw_rst    = wr_en && reg_hit(page, addr, PG_CORE, RA_SWRST) && wdata[B_SWRST];
    assign master    = rst || sw_rst;
    assign wr_hp     = wr_en && reg_hit(page, addr, PG_DRV, RA_HP);
    assign wr_spk    = wr_en && reg_hit(page, addr, PG_DRV, RA_SPK);
    assign stage_clr = wr_spk && wdata[B_PWR] && oc_latched;

    always_ff @(posedge clk) begin
        if (master) begin
            hp_pwr     <= 1'b0;
            spk_pwr    <= 1'b0;
            oc_latched <= 1'b0;
            rst_cnt    <= '0;
        end else begin
            if (wr_hp)  hp_pwr  <= wdata[B_PWR];
            if (wr_spk) spk_pwr <= wdata[B_PWR];
            if (oc_s)           oc_latched <= 1'b1;
            else if (stage_clr) oc_latched <= 1'b0;
            if (stage_clr && (rst_cnt != '1)) rst_cnt <= rst_cnt + 1'b1;
        end
    end

    assign warn = (rst_cnt > CNT_W'(WARN_AT));

    always_comb begin
        rdata = '0;
        if (reg_hit(page, addr, PG_CORE, RA_STAT)) begin
            rdata[B_OC]     = oc_latched;
            rdata[B_OT]     = ot_s;
            rdata[B_WARN]   = warn;
            rdata[B_HPRDY]  = hp_ready;
            rdata[B_SPKRDY] = spk_ready;
        end else if (reg_hit(page, addr, PG_DRV, RA_HP)) begin
            rdata[B_PWR] = hp_pwr;
        end else if (reg_hit(page, addr, PG_DRV, RA_SPK)) begin
            rdata[B_PWR] = spk_pwr;
        end
    end
endmodule

// File: rtl/spk_guard.sv
module spk_guard
    import spk_guard_pkg::*;
#(
    parameter int RAMP_LEN = 256,
    parameter int CNT_W    = 3,
    parameter int WARN_AT  = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] page,
    input  logic [6:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       oc_in,
    input  logic       ot_in,
    output logic       hp_en,
    output logic       hp_ramp,
    output logic       hp_ready,
    output logic       spk_en,
    output logic       spk_ramp,
    output logic       spk_ready,
    output logic       spk_sw_en
);
    logic [1:0]  flt_s;
    logic        oc_s, ot_s;
    logic        master, hp_pwr, spk_pwr, oc_latched, stage_clr, warn;
    logic [N_STAGE-1:0] req;
    stage_stat_t stat [N_STAGE];

    sg_sync #(.W(2), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ot_in, oc_in}),
        .q   (flt_s)
    );
    assign oc_s = flt_s[0];
    assign ot_s = flt_s[1];

    sg_ctrl #(.CNT_W(CNT_W), .WARN_AT(WARN_AT)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .page       (page),
        .addr       (addr),
        .wdata      (wdata),
        .oc_s       (oc_s),
        .ot_s       (ot_s),
        .hp_ready   (stat[IDX_HP].ready),
        .spk_ready  (stat[IDX_SPK].ready),
        .master     (master),
        .hp_pwr     (hp_pwr),
        .spk_pwr    (spk_pwr),
        .oc_latched (oc_latched),
        .stage_clr  (stage_clr),
        .warn       (warn),
        .rdata      (rdata)
    );

    assign req[IDX_HP]  = hp_pwr;
    assign req[IDX_SPK] = spk_pwr && !oc_latched;

    for (genvar g = 0; g < N_STAGE; g++) begin : g_stage
        sg_ramp #(.RAMP_LEN(RAMP_LEN)) u_ramp (
            .clk  (clk),
            .clr  (master),
            .req  (req[g]),
            .stat (stat[g])
        );
    end

    assign hp_en     = stat[IDX_HP].en;
    assign hp_ramp   = stat[IDX_HP].ramp;
    assign hp_ready  = stat[IDX_HP].ready;
    assign spk_en    = stat[IDX_SPK].en;
    assign spk_ramp  = stat[IDX_SPK].ramp;
    assign spk_ready = stat[IDX_SPK].ready;
    assign spk_sw_en = stat[IDX_SPK].en && !ot_s;
endmodule

// File: rtl/spk_guard_chk.sv
module spk_guard_chk (
    input logic clk,
    input logic rst,
    input logic ot_in,
    input logic master,
    input logic hp_pwr,
    input logic oc_latched,
    input logic stage_clr,
    input logic warn,
    input logic hp_en,
    input logic hp_ramp,
    input logic hp_ready,
    input logic spk_en,
    input logic spk_ramp,
    input logic spk_ready,
    input logic spk_sw_en
);
    // R3
    hp_ready_after_ramp_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hp_ready) |-> $past(hp_ramp));

    // R3
    spk_ready_after_ramp_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(spk_ready) |-> $past(spk_ramp));

    // R4
    ramp_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (hp_ramp && !hp_pwr) |=> !hp_en);

    // R5
    oc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (oc_latched && !stage_clr && !master) |=> oc_latched);

    // R8
    oc_blocks_spk_chk: assert property (@(posedge clk) disable iff (rst)
        (oc_latched && $past(oc_latched)) |-> !spk_en);

    // R9
    ot_stops_switch_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(ot_in, 2)) |-> !spk_sw_en);

    // R11
    warn_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (warn && !master) |=> warn);
endmodule

bind spk_guard spk_guard_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ot_in      (ot_in),
    .master     (master),
    .hp_pwr     (hp_pwr),
    .oc_latched (oc_latched),
    .stage_clr  (stage_clr),
    .warn       (warn),
    .hp_en      (hp_en),
    .hp_ramp    (hp_ramp),
    .hp_ready   (hp_ready),
    .spk_en     (spk_en),
    .spk_ramp   (spk_ramp),
    .spk_ready  (spk_ready),
    .spk_sw_en  (spk_sw_en)
);

// File: tb/spk_guard_test.sv
`timescale 1ns/1ps
module spk_guard_test;
    localparam int L = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] page = '0;
    logic [6:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       oc_in = 1'b0, ot_in = 1'b0;
    logic [7:0] rdata;
    logic       hp_en, hp_ramp, hp_ready, spk_en, spk_ramp, spk_ready, spk_sw_en;

    int    checks = 0, bad = 0, cyc = 0;
    string tag = "R1";
    bit    started = 1'b0;

    always #2.5 clk = ~clk;

    spk_guard #(.RAMP_LEN(L), .CNT_W(3), .WARN_AT(3)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .page(page), .addr(addr), .wdata(wdata),
        .rdata(rdata), .oc_in(oc_in), .ot_in(ot_in),
        .hp_en(hp_en), .hp_ramp(hp_ramp), .hp_ready(hp_ready),
        .spk_en(spk_en), .spk_ramp(spk_ramp), .spk_ready(spk_ready), .spk_sw_en(spk_sw_en)
    );

    // behavioural reference model
    logic m_hp, m_spk, m_oc, m_oc1, m_oc2, m_ot1, m_ot2, m_soft, m_clr;
    logic [1:0] m_req;
    int   m_cnt;
    int   m_st [2];
    int   m_rc [2];

    always @(posedge clk) begin
        started = 1'b1;
        m_soft = wr_en && page == 8'd0 && addr == 7'd1 && wdata[0];
        m_req[0] = m_hp;
        m_req[1] = m_spk && !m_oc;
        if (rst || m_soft) begin
            m_hp = 0; m_spk = 0; m_oc = 0; m_cnt = 0;
            for (int i = 0; i < 2; i++) begin m_st[i] = 0; m_rc[i] = 0; end
        end else begin
            m_clr = wr_en && page == 8'd1 && addr == 7'd32 && wdata[7] && m_oc;
            for (int i = 0; i < 2; i++) begin
                if (!m_req[i]) begin m_st[i] = 0; m_rc[i] = 0; end
                else if (m_st[i] == 0) begin m_st[i] = 1; m_rc[i] = 0; end
                else if (m_st[i] == 1) begin
                    if (m_rc[i] == L - 1) m_st[i] = 2; else m_rc[i]++;
                end
            end
            if (wr_en && page == 8'd1 && addr == 7'd31) m_hp = wdata[7];
            if (wr_en && page == 8'd1 && addr == 7'd32) m_spk = wdata[7];
            if (m_oc2) m_oc = 1; else if (m_clr) m_oc = 0;
            if (m_clr && m_cnt < 7) m_cnt++;
        end
        if (rst) begin
            m_oc1 = 0; m_oc2 = 0; m_ot1 = 0; m_ot2 = 0;
        end else begin
            m_oc2 = m_oc1; m_oc1 = oc_in; m_ot2 = m_ot1; m_ot1 = ot_in;
        end
    end

    function automatic logic [7:0] m_rdata();
        logic [7:0] r = '0;
        if (page == 8'd0 && addr == 7'd3)
            r = {3'b0, m_st[1] == 2, m_st[0] == 2, m_cnt > 3, m_ot2, m_oc};
        else if (page == 8'd1 && addr == 7'd31) r = {m_hp, 7'b0};
        else if (page == 8'd1 && addr == 7'd32) r = {m_spk, 7'b0};
        return r;
    endfunction

    task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk("hp_en",     {7'b0, hp_en},     {7'b0, m_st[0] != 0});
            chk("hp_ramp",   {7'b0, hp_ramp},   {7'b0, m_st[0] == 1});
            chk("hp_ready",  {7'b0, hp_ready},  {7'b0, m_st[0] == 2});
            chk("spk_en",    {7'b0, spk_en},    {7'b0, m_st[1] != 0});
            chk("spk_ramp",  {7'b0, spk_ramp},  {7'b0, m_st[1] == 1});
            chk("spk_ready", {7'b0, spk_ready}, {7'b0, m_st[1] == 2});
            chk("spk_sw_en", {7'b0, spk_sw_en}, {7'b0, (m_st[1] != 0) && !m_ot2});
            chk("rdata",     rdata,             m_rdata());
        end
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", checks, bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            bad++;
            $display("FAIL watchdog: actual=%0d expected<=50000 cycles", cyc);
            summary();
            $finish;
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(logic [7:0] p, logic [6:0] a, logic [7:0] d);
        page = p; addr = a; wdata = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic look(logic [7:0] p, logic [6:0] a);
        page = p; addr = a;
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        look(0, 3);
        tick(3);
        rst = 1'b0;
        tick(2);
        // R2: headphone power-up alone
        tag = "R2";
        wr(1, 31, 8'h80);
        look(1, 31);
        tick(L + 3);
        // R3: speaker ramp and ready status
        tag = "R3";
        wr(1, 32, 8'h80);
        look(0, 3);
        tick(L + 3);
        // R4: abort during ramp
        tag = "R4";
        wr(1, 31, 8'h00);
        wr(1, 31, 8'h80);
        tick(5);
        wr(1, 31, 8'h00);
        tick(3);
        wr(1, 31, 8'h80);
        tick(L + 2);
        // R5: overcurrent latches and persists
        tag = "R5";
        oc_in = 1'b1;
        tick(4);
        oc_in = 1'b0;
        tick(10);
        // R6: stage reset clears latch, headphone untouched
        tag = "R6";
        wr(1, 32, 8'h80);
        tick(L + 3);
        // R7: stage reset while fault still present
        tag = "R7";
        oc_in = 1'b1;
        tick(4);
        wr(1, 32, 8'h80);
        tick(4);
        oc_in = 1'b0;
        tick(4);
        wr(1, 32, 8'h80);
        tick(L + 2);
        // R8: overcurrent beats same-cycle power-up
        tag = "R8";
        wr(1, 32, 8'h00);
        tick(2);
        oc_in = 1'b1;
        tick(2);
        wr(1, 32, 8'h80);
        oc_in = 1'b0;
        tick(L + 2);
        wr(1, 32, 8'h80);
        tick(L + 2);
        // R9: overtemperature pauses switching, status write ignored
        tag = "R9";
        ot_in = 1'b1;
        tick(5);
        wr(0, 3, 8'hFF);
        tick(3);
        ot_in = 1'b0;
        tick(5);
        // R11: repeated stage resets saturate counter
        tag = "R11";
        for (int k = 0; k < 6; k++) begin
            oc_in = 1'b1;
            tick(4);
            oc_in = 1'b0;
            tick(3);
            wr(1, 32, 8'h80);
            tick(2);
        end
        tick(L);
        // R10: software reset then pin reset
        tag = "R10";
        wr(0, 1, 8'h01);
        tick(3);
        wr(1, 31, 8'h80);
        wr(1, 32, 8'h80);
        tick(L + 2);
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(3);
        summary();
        $finish;
    end
endmodule